// File: doc/BRIEF.md
# Serial Byte Receiver with Stop-Bit Error Flag

This block is an asynchronous serial receiver. An external baud generator supplies a one-cycle tick at sixteen times the bit rate. On each tick the receiver samples a synchronised copy of the serial line. It finds the start bit and collects eight data bits, least significant bit first. It then checks the stop bit. Every completed byte goes into a data holding register, whether or not the stop bit was valid.

A status word reports two flags: "byte waiting" and "stop-bit error". The error flag has no interrupt of its own. It always rises in the same clock cycle as the byte-waiting flag, and only the byte-waiting flag, gated by an enable input, drives the interrupt request.

Software reads the two registers through a strobe and a one-bit select. Both flags are cleared only by a fixed two-step sequence: first a status read while a flag is set, then a data read. After a break, where the line stays low through the stop position, the receiver waits for the line to go high again before it looks for the next start bit.

Top module: `rxu_top`

## Requirements
- R1: A low level on the line is taken as a start bit only if the line is still low on the 8th tick after the tick that first saw it low. Otherwise the receiver returns to idle and stores nothing.
- R2: Data bits are sampled every 16 ticks after the start-bit centre, least significant bit first. A data read (`rd_sel`=1) returns the assembled byte.
- R3: At the end of each frame the byte is stored and status bit 0 (byte waiting) becomes 1. Status bit 1 (stop-bit error) becomes 1 if the line was low at the stop-bit centre, and stays 0 if it was high. The byte is stored even when the stop bit is bad.
- R4: The stop-bit error flag rises only in the same cycle as the end of a frame. `rx_irq` is 1 exactly when status bit 0 is 1 and `rx_int_en` is 1, whatever the value of bit 1.
- R5: A status read (`rd_sel`=0) made while either flag is set arms a clear. A following data read then clears both flags.
- R6: A data read that no armed status read came before leaves both flags unchanged.
- R7: A break (all-zero data with the line low at the stop position) sets both flags. No new start bit is accepted until the line has been high on a tick.
- R8: After reset both flags are 0, the status word reads 0 and `rx_irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick16 | input | 1 | One-cycle pulse at 16x the bit rate |
| rx_line | input | 1 | Serial input, idle high |
| rx_int_en | input | 1 | Receive interrupt enable |
| rd_stb | input | 1 | Register read strobe, one cycle per read |
| rd_sel | input | 1 | 0 selects the status word, 1 selects the data byte |
| rd_data | output | 8 | Read data for the selected register |
| rx_irq | output | 1 | Interrupt request |

## Verification
A table of frames is sent, with varied bit patterns (alternating bits, all ones, all zeros, single end bits), a high or low stop bit, and the interrupt enable on or off. These show that bit order is correct, that the error flag follows only the stop sample, and that the interrupt ignores the error flag. Directed tests cover a short low glitch, which tells real start bits from noise. They also cover a long break that holds the line low after it is cleared, which shows whether the receiver wrongly re-triggers. A data read issued without the status read shows whether the clear sequence depends on order.

// File: rtl/rxu_pkg.sv
package rxu_pkg;

    // receive sequencer states
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_START   = 3'd1,
        ST_DATA    = 3'd2,
        ST_STOP    = 3'd3,
        ST_BRKWAIT = 3'd4
    } rx_state_e;

    // register select encoding
    localparam logic SEL_STATUS = 1'b0;
    localparam logic SEL_DATA   = 1'b1;

    // status word bit positions
    localparam int STAT_FULL_BIT = 0;
    localparam int STAT_ERR_BIT  = 1;

endpackage

// File: rtl/rxu_sync.sv
module rxu_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_st;

    sync_st s_d, s_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb begin
                s_d = s_q;
                s_d.chain[0] = d_in;
            end
        end else begin : g_multi
            always_comb begin
                s_d = s_q;
                s_d.chain = {s_q.chain[STAGES-2:0], d_in};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{chain: '1};
        else        s_q <= s_d;
    end

    assign d_out = s_q.chain[STAGES-1];

endmodule

// File: rtl/rxu_frame.sv
module rxu_frame
    import rxu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              rx_i,
    output logic              done_o,
    output logic              bad_o,
    output logic [DATA_W-1:0] byte_o
);

    localparam int CNT_W = $clog2(OVS);
    localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OVS / 2 - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(OVS - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

    typedef struct packed {
        rx_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic [BIT_W-1:0]  bidx;
        logic [DATA_W-1:0] shreg;
        logic [DATA_W-1:0] dout;
        logic              done;
        logic              bad;
    } frm_st;

    frm_st f_d, f_q;

    always_comb begin
        f_d      = f_q;
        f_d.done = 1'b0;
        if (tick_i) begin
            unique case (f_q.state)
                ST_IDLE: begin
                    if (!rx_i) begin
                        f_d.state = ST_START;
                        f_d.cnt   = '0;
                    end
                end
                ST_START: begin
                    if (f_q.cnt == CNT_MID) begin
                        f_d.cnt  = '0;
                        f_d.bidx = '0;
                        f_d.state = rx_i ? ST_IDLE : ST_DATA;
                    end else begin
                        f_d.cnt = f_q.cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (f_q.cnt == CNT_FULL) begin
                        f_d.cnt = '0;
                        if (DATA_W > 1)
                            f_d.shreg = {rx_i, f_q.shreg[DATA_W-1:1]};
                        else
                            f_d.shreg = rx_i;
                        if (f_q.bidx == BIT_LAST) f_d.state = ST_STOP;
                        else                      f_d.bidx  = f_q.bidx + 1'b1;
                    end else begin
                        f_d.cnt = f_q.cnt + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (f_q.cnt == CNT_FULL) begin
                        f_d.cnt  = '0;
                        f_d.done = 1'b1;
                        f_d.bad  = !rx_i;
                        f_d.dout = f_q.shreg;
                        if (!rx_i && (f_q.shreg == '0)) f_d.state = ST_BRKWAIT;
                        else                            f_d.state = ST_IDLE;
                    end else begin
                        f_d.cnt = f_q.cnt + 1'b1;
                    end
                end
                ST_BRKWAIT: begin
                    if (rx_i) f_d.state = ST_IDLE;
                end
                default: f_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '{state: ST_IDLE, default: '0};
        else        f_q <= f_d;
    end

    assign done_o = f_q.done;
    assign bad_o  = f_q.bad;
    assign byte_o = f_q.dout;

    AST_DONE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(tick_i)) else $error("frame end without tick"); // R2

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o) else $error("frame end lasted two cycles"); // R3

    AST_BRK_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.state == ST_BRKWAIT && !rx_i) |=> (f_q.state == ST_BRKWAIT))
        else $error("left break wait while line low"); // R7

endmodule

// File: rtl/rxu_regs.sv
module rxu_regs
    import rxu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_done_i,
    input  logic              frm_bad_i,
    input  logic [DATA_W-1:0] frm_byte_i,
    input  logic              rd_stb_i,
    input  logic              rd_sel_i,
    input  logic              int_en_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              irq_o
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              full;
        logic              err;
        logic              armed;
    } reg_st;

    reg_st r_d, r_q;

    logic stat_rd, data_rd;

    assign stat_rd = rd_stb_i && (rd_sel_i == SEL_STATUS);
    assign data_rd = rd_stb_i && (rd_sel_i == SEL_DATA);

    always_comb begin
        r_d = r_q;
        if (stat_rd && (r_q.full || r_q.err))
            r_d.armed = 1'b1;
        if (data_rd && r_q.armed) begin
            r_d.full  = 1'b0;
            r_d.err   = 1'b0;
            r_d.armed = 1'b0;
        end
        if (frm_done_i) begin
            r_d.data  = frm_byte_i;
            r_d.full  = 1'b1;
            r_d.err   = r_d.err | frm_bad_i;
            r_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rd_data_o = '0;
        if (rd_sel_i == SEL_DATA) begin
            rd_data_o = r_q.data;
        end else begin
            rd_data_o[STAT_FULL_BIT] = r_q.full;
            rd_data_o[STAT_ERR_BIT]  = r_q.err;
        end
    end

    assign irq_o = r_q.full && int_en_i;

    AST_ERR_WITH_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.err) |-> ($past(frm_done_i) && r_q.full))
        else $error("error flag rose outside a frame end"); // R4

    AST_ERR_CLEAR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.err) |-> $past(data_rd && r_q.armed))
        else $error("error flag cleared without armed data read"); // R5

    AST_UNARMED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.full && data_rd && !r_q.armed) |=> r_q.full)
        else $error("unarmed data read cleared the byte flag"); // R6

    AST_IRQ_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (rd_data_o[STAT_FULL_BIT] || rd_sel_i == SEL_DATA))
        else $error("interrupt without a waiting byte"); // R4

endmodule

// File: rtl/rxu_top.sv
module rxu_top
    import rxu_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick16,
    input  logic              rx_line,
    input  logic              rx_int_en,
    input  logic              rd_stb,
    input  logic              rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic              rx_irq
);

    logic              rx_s;
    logic              frm_done;
    logic              frm_bad;
    logic [DATA_W-1:0] frm_byte;

    rxu_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (rx_line),
        .d_out (rx_s)
    );

    rxu_frame #(.DATA_W(DATA_W), .OVS(OVS)) i_frame (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (baud_tick16),
        .rx_i   (rx_s),
        .done_o (frm_done),
        .bad_o  (frm_bad),
        .byte_o (frm_byte)
    );

    rxu_regs #(.DATA_W(DATA_W)) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .frm_done_i (frm_done),
        .frm_bad_i  (frm_bad),
        .frm_byte_i (frm_byte),
        .rd_stb_i   (rd_stb),
        .rd_sel_i   (rd_sel),
        .int_en_i   (rx_int_en),
        .rd_data_o  (rd_data),
        .irq_o      (rx_irq)
    );

endmodule

// File: tb/test_rxu_top.sv
module test_rxu_top;

    localparam int CLK_P   = 10;
    localparam int TDIV    = 8;
    localparam int NVEC    = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick16 = 1'b0;
    logic       rx_line = 1'b1;
    logic       rx_int_en = 1'b0;
    logic       rd_stb = 1'b0;
    logic       rd_sel = 1'b0;
    logic [7:0] rd_data;
    logic       rx_irq;

    int total = 0;
    int bad   = 0;
    int tcnt  = 0;

    // vector: {data[7:0], stop_high, int_en}
    localparam logic [9:0] VEC [NVEC] = '{
        {8'h55, 1'b1, 1'b1},
        {8'hA3, 1'b0, 1'b0},
        {8'hFF, 1'b1, 1'b0},
        {8'h81, 1'b0, 1'b1},
        {8'h00, 1'b1, 1'b1},
        {8'h7E, 1'b1, 1'b0}
    };

    rxu_top i_rxu_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .baud_tick16 (baud_tick16),
        .rx_line     (rx_line),
        .rx_int_en   (rx_int_en),
        .rd_stb      (rd_stb),
        .rd_sel      (rd_sel),
        .rd_data     (rd_data),
        .rx_irq      (rx_irq)
    );

    always #(CLK_P/2) clk = ~clk;

    initial begin
        forever begin
            @(negedge clk);
            tcnt = (tcnt + 1) % TDIV;
            baud_tick16 = (tcnt == 0);
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic align();
        do begin
            @(negedge clk);
            #1;
        end while (tcnt != 0);
    endtask

    task automatic hold(input int nticks);
        repeat (nticks * TDIV) @(negedge clk);
        #1;
    endtask

    task automatic rd(input logic sel, output logic [7:0] val);
        @(negedge clk);
        #1;
        rd_stb = 1'b1;
        rd_sel = sel;
        #1;
        val = rd_data;
        @(negedge clk);
        #1;
        rd_stb = 1'b0;
        rd_sel = 1'b0;
    endtask

    task automatic send(input logic [7:0] b, input logic stop_hi, input int idle_ticks);
        align();
        rx_line = 1'b0;
        hold(16);
        for (int k = 0; k < 8; k++) begin
            rx_line = b[k];
            hold(16);
        end
        rx_line = stop_hi;
        hold(16);
        rx_line = 1'b1;
        if (idle_ticks > 0) hold(idle_ticks);
    endtask

    task automatic clear_seq();
        logic [7:0] v;
        rd(1'b0, v);
        rd(1'b1, v);
    endtask

    initial begin
        logic [7:0] v;
        #(CLK_P * 150000);
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #1;

        // R8 reset state
        rd(1'b0, v);
        check("R8 status after reset", v, 8'h00);
        check("R8 irq after reset", rx_irq, 1'b0);

        // table walk: R2 R3 R4 R5
        for (int i = 0; i < NVEC; i++) begin
            logic [7:0] b;
            logic       sh, ie;
            b  = VEC[i][9:2];
            sh = VEC[i][1];
            ie = VEC[i][0];
            rx_int_en = ie;
            send(b, sh, 24);
            check("R4 irq is full and enable", rx_irq, ie);
            rd(1'b0, v);
            check("R3 status flags", v, {6'b0, !sh, 1'b1});
            rd(1'b1, v);
            check("R2 byte lsb first", v, b);
            rd(1'b0, v);
            check("R5 flags cleared", v, 8'h00);
            check("R4 irq low after clear", rx_irq, 1'b0);
        end

        // R6: unarmed data read leaves flags
        rx_int_en = 1'b1;
        send(8'hC6, 1'b0, 24);
        rd(1'b1, v);
        check("R6 data read value", v, 8'hC6);
        rd(1'b0, v);
        check("R6 flags kept after unarmed read", v, 8'h03);
        rd(1'b1, v);
        rd(1'b0, v);
        check("R5 cleared after status then data", v, 8'h00);

        // R1: short low glitch is not a start bit
        align();
        rx_line = 1'b0;
        hold(4);
        rx_line = 1'b1;
        hold(200);
        rd(1'b0, v);
        check("R1 glitch leaves no byte", v, 8'h00);
        check("R1 glitch no irq", rx_irq, 1'b0);

        // R7: break then line held low
        align();
        rx_line = 1'b0;
        hold(16 * 10 + 48);
        rd(1'b0, v);
        check("R7 break sets both flags", v, 8'h03);
        rd(1'b1, v);
        check("R7 break byte is zero", v, 8'h00);
        rd(1'b0, v);
        check("R7 break flags cleared", v, 8'h00);
        hold(400);
        rd(1'b0, v);
        check("R7 no restart while line low", v, 8'h00);
        rx_line = 1'b1;
        hold(20);
        send(8'h3C, 1'b1, 24);
        rd(1'b0, v);
        check("R7 frame after break status", v, 8'h01);
        rd(1'b1, v);
        check("R7 frame after break byte", v, 8'h3C);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule